// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides which of eight interrupt request lines, if any, should be forwarded to the processor. It takes three 8-bit vectors: pending requests, a mask, and the set of lines currently being serviced. It also takes a 3-bit rotation offset, a special-fully-nested enable and a master/slave strap. From these it finds the unmasked pending line with the highest priority. It raises a request only when that line outranks every level still in service.

Priorities rotate. The offset names the physical line that holds the top priority, and the other lines follow it in ascending order, wrapping around. On a master controller running in special fully nested mode, the cascade line (line 2 by default) is left out when the current in-service level is worked out. A second request from the slave can then pass through while an earlier slave interrupt is still being serviced.

The block is purely combinational and has no clock. Each controller instance in a cascade gets its own copy. Register storage, command decoding and acknowledge handling belong to the surrounding logic.

Top module: `rpr_resolver`

## Requirements
- R1: A line is a candidate only when its request bit is 1 and its mask bit is 0. A masked line is never reported.
- R2: Priority position p corresponds to physical line (p + rot_off) mod 8. Position 0 is the highest priority, and the candidate with the lowest position wins.
- R3: When there is no candidate, int_valid is 0.
- R4: When no in-service bit counts toward the current level and at least one candidate exists, int_valid is 1.
- R5: int_valid is 1 only when the winning candidate's position is strictly lower than the position of the highest-priority counted in-service line. Equal positions give 0.
- R6: When is_master = 1 and sfn_en = 1, in-service bit 2 is ignored when the current in-service level is computed.
- R7: When is_master = 0 or sfn_en = 0, in-service bit 2 counts like any other line.
- R8: irq_line is 0 whenever int_valid is 0.
- R9: When int_valid is 1, irq_line holds the physical line number of the winner, which is (winning position + rot_off) mod 8.
- R10: The outputs follow the inputs without any clock or stored state. The same inputs always give the same outputs, whatever came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_vec | input | 8 | Pending request bits, one per line |
| mask_vec | input | 8 | Mask bits; 1 blocks the line |
| insvc_vec | input | 8 | In-service bits, one per line |
| rot_off | input | 3 | Physical line holding the top priority |
| sfn_en | input | 1 | Special fully nested mode enable |
| is_master | input | 1 | 1 when this instance is the master controller |
| int_valid | output | 1 | Request to the processor |
| irq_line | output | 3 | Winning physical line; 0 when int_valid is 0 |

## Verification
Because the block holds no state, any fault shows up at the ports for the same input combination that exposes it. It never lingers or shows up later. A wrong rotation shows up as a different irq_line when two candidates straddle the offset. A wrong in-service comparison shows up as int_valid toggling at exactly the equal-position boundary. A cascade exclusion applied to the wrong instance or the wrong bit flips int_valid only when in-service bit 2 is the top counted level. Sweeping every offset with random vectors reaches each of these cases within a few hundred input patterns.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    localparam int unsigned RPR_DEF_LINES   = 8;
    localparam int unsigned RPR_DEF_CASCADE = 2;

    typedef enum logic [0:0] {
        RPR_SLAVE  = 1'b0,
        RPR_MASTER = 1'b1
    } rpr_role_e;
endpackage

// File: rtl/rpr_rotate.sv
module rpr_rotate #(
    parameter int unsigned N  = 8,
    localparam int unsigned OW = $clog2(N)
) (
    input  logic [N-1:0]  vec_in,
    input  logic [OW-1:0] off,
    output logic [N-1:0]  vec_out
);
    // Position p of the output views physical line (p + off) mod N.
    for (genvar p = 0; p < N; p++) begin : g_pos
        logic [OW-1:0] src_idx;
        always_comb begin
            src_idx = OW'((p + int'(off)) % N);
        end
        assign vec_out[p] = vec_in[src_idx];
    end
endmodule

// File: rtl/rpr_prio_scan.sv
module rpr_prio_scan #(
    parameter int unsigned N  = 8,
    localparam int unsigned PW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [PW-1:0] pos
);
    // Lowest set position; N when the vector is empty.
    always_comb begin
        pos = PW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos = PW'(i);
            end
        end
    end
endmodule

// File: rtl/rpr_resolver.sv
module rpr_resolver #(
    parameter int unsigned N_LINES   = rpr_pkg::RPR_DEF_LINES,
    parameter int unsigned CASCADE   = rpr_pkg::RPR_DEF_CASCADE,
    localparam int unsigned OW       = $clog2(N_LINES),
    localparam int unsigned PW       = $clog2(N_LINES + 1)
) (
    input  logic [N_LINES-1:0] req_vec,
    input  logic [N_LINES-1:0] mask_vec,
    input  logic [N_LINES-1:0] insvc_vec,
    input  logic [OW-1:0]      rot_off,
    input  logic               sfn_en,
    input  logic               is_master,
    output logic               int_valid,
    output logic [OW-1:0]      irq_line
);
    typedef struct packed {
        logic          valid;
        logic [OW-1:0] line;
    } res_t;

    logic [N_LINES-1:0] cand_d;
    logic [N_LINES-1:0] level_d;
    logic [N_LINES-1:0] cand_rot_d;
    logic [N_LINES-1:0] level_rot_d;
    logic [PW-1:0]      cand_pos_d;
    logic [PW-1:0]      level_pos_d;
    res_t               res_d;

    // Candidate set and counted in-service set.
    always_comb begin
        cand_d  = req_vec & ~mask_vec;
        level_d = insvc_vec;
        if ((rpr_pkg::rpr_role_e'(is_master) == rpr_pkg::RPR_MASTER) && sfn_en) begin
            level_d[CASCADE] = 1'b0;
        end
    end

    rpr_rotate #(.N(N_LINES)) u_rot_cand (
        .vec_in (cand_d),
        .off    (rot_off),
        .vec_out(cand_rot_d)
    );

    rpr_rotate #(.N(N_LINES)) u_rot_level (
        .vec_in (level_d),
        .off    (rot_off),
        .vec_out(level_rot_d)
    );

    rpr_prio_scan #(.N(N_LINES)) u_scan_cand (
        .vec(cand_rot_d),
        .pos(cand_pos_d)
    );

    rpr_prio_scan #(.N(N_LINES)) u_scan_level (
        .vec(level_rot_d),
        .pos(level_pos_d)
    );

    // Compare positions and map the winner back to a physical line.
    always_comb begin
        res_d = '0;
        if (cand_pos_d < level_pos_d) begin
            res_d.valid = 1'b1;
            res_d.line  = OW'((int'(cand_pos_d) + int'(rot_off)) % N_LINES);
        end
    end

    assign int_valid = res_d.valid;
    assign irq_line  = res_d.line;
endmodule

// File: rtl/rpr_resolver_chk.sv
module rpr_resolver_chk #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned CASCADE = 2,
    localparam int unsigned OW     = $clog2(N_LINES)
) (
    input logic [N_LINES-1:0] req_vec,
    input logic [N_LINES-1:0] mask_vec,
    input logic [N_LINES-1:0] insvc_vec,
    input logic [OW-1:0]      rot_off,
    input logic               sfn_en,
    input logic               is_master,
    input logic               int_valid,
    input logic [OW-1:0]      irq_line
);
    logic [N_LINES-1:0] cand;
    logic [N_LINES-1:0] counted;
    logic               known;

    always_comb begin
        cand    = req_vec & ~mask_vec;
        counted = insvc_vec;
        if (is_master && sfn_en) counted[CASCADE] = 1'b0;
        known   = !$isunknown({req_vec, mask_vec, insvc_vec, rot_off, sfn_en, is_master,
                               int_valid, irq_line});
    end

    always_comb begin
        if (known) begin
            // R8
            idle_line_zero_chk: assert (int_valid || irq_line == '0);
            // R1
            winner_is_cand_chk: assert (!int_valid || cand[irq_line]);
            // R3
            no_cand_quiet_chk: assert (cand != '0 || !int_valid);
            // R4
            free_level_fires_chk: assert (!(cand != '0 && counted == '0) || int_valid);
            // R5
            winner_not_busy_chk: assert (!int_valid || !counted[irq_line]);
            // R5
            top_busy_blocks_chk: assert (!counted[rot_off] || !int_valid);
            // R2
            top_cand_wins_chk: assert (!(cand[rot_off] && !counted[rot_off])
                                       || (int_valid && irq_line == rot_off));
        end
    end
endmodule

bind rpr_resolver rpr_resolver_chk #(.N_LINES(N_LINES), .CASCADE(CASCADE)) u_chk (
    .req_vec  (req_vec),
    .mask_vec (mask_vec),
    .insvc_vec(insvc_vec),
    .rot_off  (rot_off),
    .sfn_en   (sfn_en),
    .is_master(is_master),
    .int_valid(int_valid),
    .irq_line (irq_line)
);

// File: tb/rpr_resolver_tb.sv
module rpr_resolver_tb_top;
    logic       clk = 1'b0;
    logic [7:0] req_vec   = '0;
    logic [7:0] mask_vec  = '0;
    logic [7:0] insvc_vec = '0;
    logic [2:0] rot_off   = '0;
    logic       sfn_en    = 1'b0;
    logic       is_master = 1'b0;
    logic       int_valid;
    logic [2:0] irq_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rpr_resolver dut_i (
        .req_vec  (req_vec),
        .mask_vec (mask_vec),
        .insvc_vec(insvc_vec),
        .rot_off  (rot_off),
        .sfn_en   (sfn_en),
        .is_master(is_master),
        .int_valid(int_valid),
        .irq_line (irq_line)
    );

    // Behavioural reference: walk the priority order from the top.
    function automatic logic [3:0] model(input logic [7:0] rq, input logic [7:0] mk,
                                         input logic [7:0] is, input int off,
                                         input bit sfn, input bit mst);
        int cand_pos  = 8;
        int level_pos = 8;
        for (int p = 7; p >= 0; p--) begin
            int ln = (p + off) % 8;
            if (rq[ln] && !mk[ln]) cand_pos = p;
            if (is[ln] && !(mst && sfn && ln == 2)) level_pos = p;
        end
        if (cand_pos < level_pos) return {1'b1, 3'((cand_pos + off) % 8)};
        return 4'b0000;
    endfunction

    task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                         input logic [2:0] off, input bit sfn, input bit mst,
                         input string req);
        logic [3:0] exp;
        @(negedge clk);
        req_vec = rq; mask_vec = mk; insvc_vec = is;
        rot_off = off; sfn_en = sfn; is_master = mst;
        #2;
        exp = model(rq, mk, is, int'(off), sfn, mst);
        checks++;
        if ({int_valid, irq_line} !== exp) begin
            errors++;
            $display("FAIL %s: req=%h mask=%h insvc=%h off=%0d sfn=%0b mst=%0b actual v=%0b l=%0d expected v=%0b l=%0d",
                     req, rq, mk, is, off, sfn, mst, int_valid, irq_line, exp[3], exp[2:0]);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Idle state: all zero -> no request, line 0 (R3, R8)
        apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, "R3 idle");
        // R1: masked line never wins
        apply(8'h08, 8'h08, 8'h00, 3'd0, 1'b0, 1'b0, "R1 masked only");
        apply(8'h09, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0, "R1 mask top line");
        // R2 / R9: rotation picks the line after the offset
        apply(8'h82, 8'h00, 8'h00, 3'd2, 1'b0, 1'b0, "R2 wrap order");
        apply(8'h82, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, "R9 no rotation");
        apply(8'h01, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, "R9 wrapped line");
        // R4: nothing in service
        apply(8'h40, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, "R4 free level");
        // R5: equal position blocks, higher passes, lower blocks
        apply(8'h10, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, "R5 equal level");
        apply(8'h08, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, "R5 outranks");
        apply(8'h20, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, "R5 below level");
        // R6: master in nested mode ignores in-service bit 2
        apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, "R6 cascade ignored");
        apply(8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, "R6 lower passes");
        // R7: slave or mode off keeps bit 2
        apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, "R7 slave");
        apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, "R7 mode off");
        // R10: same inputs after different history
        apply(8'hFF, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0, "R10 prior");
        apply(8'h10, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, "R10 repeat");
        // Sweep every offset with random vectors (R1 R2 R5 R6 R7 R8 R9)
        for (int off = 0; off < 8; off++) begin
            for (int k = 0; k < 500; k++) begin
                apply(8'($urandom), 8'($urandom & $urandom), 8'($urandom & $urandom),
                      3'(off), 1'($urandom), 1'($urandom), "R9 random sweep");
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule